// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block chooses which of eleven interrupt sources an 8-bit processor core services next, and it tracks nested service at two priority levels. Each source drives a level-sensitive request line, which the peripheral clears itself. Each source also has an enable bit and a priority bit (1 = high, 0 = low). A global enable masks every source except the watchdog. The watchdog takes part only when its interrupt mode input is set. It is then always treated as high priority, and both its own enable bit and its own priority bit are ignored.

The grant decision is registered by a two-state machine. In **IDLE** the arbiter evaluates the qualified requests against the in-service state. When a grant is allowed it takes the transition *grant* into **REQUEST**. In REQUEST the strobe is high, and the strobe and vector hold steady until the core acknowledges. The acknowledge takes the transition *take* back to IDLE and marks the granted level as in service. There is no other transition. A return-from-interrupt pulse clears the highest active in-service level.

Source indices follow the polling order, highest first: 0 supply monitor, 1 watchdog, 2 external 0, 3 ADC, 4 timer 0, 5 external 1, 6 timer 1, 7 serial bus (I2C/SPI), 8 UART, 9 timer 2, 10 interval timer.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_strobe` is 0 and `isr_level` is 2'b00.
- R2: Among qualified requests of one level, the source with the lowest index wins.
- R3: When qualified requests of both levels are pending and no level is in service, a high-level request is granted.
- R4: `irq_vector` gives the granted source's address. By index 0..10 these are 0043h, 005Bh, 0003h, 0033h, 000Bh, 0013h, 001Bh, 003Bh, 0023h, 002Bh and 0053h.
- R5: While only the low level is in service (`isr_level` = 2'b01), a qualified high-level request is granted.
- R6: No request is granted at or below an in-service level. With bit 1 set nothing is granted. With only bit 0 set, no low request is granted.
- R7: The watchdog (index 1) is qualified only when `wdt_mode` is 1. It then ignores `glob_en`, `irq_en[1]` and `irq_prio[1]`, and it is always high level.
- R8: With `glob_en` at 0, no other source is granted. A request that is still held is granted once `glob_en` returns to 1.
- R9: A source whose `irq_en` bit is 0 is never granted.
- R10: Once `irq_strobe` rises, the strobe and `irq_vector` stay unchanged until a cycle with `core_ack` high, even if the request drops.
- R11: An acknowledge sets `isr_level` bit 1 for a high grant or bit 0 for a low grant. `core_reti` clears bit 1 if it is set, and otherwise clears bit 0.
- R12: A qualified request present before a clock edge in IDLE raises `irq_strobe` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 11 | Level request per source, indexed by polling order |
| irq_en | input | 11 | Per-source enable |
| irq_prio | input | 11 | Per-source priority, 1 = high |
| glob_en | input | 1 | Global enable for the maskable sources |
| wdt_mode | input | 1 | Watchdog raises an interrupt when 1 |
| core_ack | input | 1 | Core takes the offered vector |
| core_reti | input | 1 | Core leaves a handler |
| irq_strobe | output | 1 | Interrupt request to the core |
| irq_vector | output | 16 | Vector address of the grant |
| isr_level | output | 2 | In-service flags: bit 1 high, bit 0 low |

## Verification
The bench builds the block with its fixed eleven-source configuration and a 16-bit vector. It sweeps every single source under both priority settings, and every ordered pair of distinct sources under all four priority combinations, so every polling order, level order and vector is compared with a model computed in the bench. It also sweeps every source with its enable cleared and with the global enable cleared. Directed sequences walk the in-service states through preemption, blocked requests, ordered returns and a withdrawn request during REQUEST.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC  = 11;
    localparam int IDXW  = $clog2(NSRC);
    localparam int VEC_W = 16;
    localparam int WDT_IDX = 1;

    typedef enum logic {ST_IDLE, ST_REQUEST} arb_state_e;

    function automatic logic [VEC_W-1:0] vec_addr(input logic [IDXW-1:0] idx);
        logic [VEC_W-1:0] v;
        unique case (idx)
            4'd0:    v = 16'h0043;
            4'd1:    v = 16'h005B;
            4'd2:    v = 16'h0003;
            4'd3:    v = 16'h0033;
            4'd4:    v = 16'h000B;
            4'd5:    v = 16'h0013;
            4'd6:    v = 16'h001B;
            4'd7:    v = 16'h003B;
            4'd8:    v = 16'h0023;
            4'd9:    v = 16'h002B;
            4'd10:   v = 16'h0053;
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] prio,
    input  logic            glob_en,
    input  logic            wdt_mode,
    output logic [NSRC-1:0] hi_pend,
    output logic [NSRC-1:0] lo_pend
);
    logic unused_wdt_bits;
    assign unused_wdt_bits = en[WDT_IDX] ^ prio[WDT_IDX];

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == WDT_IDX) begin : g_wdt
            assign hi_pend[i] = req[i] & wdt_mode;
            assign lo_pend[i] = 1'b0;
        end else begin : g_mask
            logic live;
            assign live       = req[i] & en[i] & glob_en;
            assign hi_pend[i] = live & prio[i];
            assign lo_pend[i] = live & ~prio[i];
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    output logic            found,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        found = |pend;
        idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take_hi,
    input  logic       take_lo,
    input  logic       reti,
    output logic [1:0] active
);
    logic hi_q, lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            if (take_hi)      hi_q <= 1'b1;
            else if (reti && hi_q) hi_q <= 1'b0;
            if (take_lo)      lo_q <= 1'b1;
            else if (reti && !hi_q) lo_q <= 1'b0;
        end
    end

    assign active = {hi_q, lo_q};

    // R11
    reti_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && hi_q && !take_hi && !take_lo) |=> (!hi_q && $stable(lo_q)));
    // R11
    take_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_hi |=> hi_q);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  irq_req,
    input  logic [NSRC-1:0]  irq_en,
    input  logic [NSRC-1:0]  irq_prio,
    input  logic             glob_en,
    input  logic             wdt_mode,
    input  logic             core_ack,
    input  logic             core_reti,
    output logic             irq_strobe,
    output logic [VEC_W-1:0] irq_vector,
    output logic [1:0]       isr_level
);
    logic [NSRC-1:0] hi_pend, lo_pend;
    logic            hi_found, lo_found;
    logic [IDXW-1:0] hi_idx, lo_idx;

    irq_qualify u_qual (
        .req(irq_req), .en(irq_en), .prio(irq_prio),
        .glob_en(glob_en), .wdt_mode(wdt_mode),
        .hi_pend(hi_pend), .lo_pend(lo_pend)
    );
    irq_pick u_pick_hi (.pend(hi_pend), .found(hi_found), .idx(hi_idx));
    irq_pick u_pick_lo (.pend(lo_pend), .found(lo_found), .idx(lo_idx));

    arb_state_e      state_q, state_d;
    logic [IDXW-1:0] sel_idx_q, sel_idx_d;
    logic            sel_hi_q, sel_hi_d;
    logic            take;

    // Grant eligibility against the in-service flags.
    logic cand_ok, cand_hi;
    logic [IDXW-1:0] cand_idx;
    always_comb begin
        cand_ok  = 1'b0;
        cand_hi  = 1'b0;
        cand_idx = '0;
        if (hi_found && !isr_level[1]) begin
            cand_ok  = 1'b1;
            cand_hi  = 1'b1;
            cand_idx = hi_idx;
        end else if (lo_found && isr_level == 2'b00) begin
            cand_ok  = 1'b1;
            cand_idx = lo_idx;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d   = state_q;
        sel_idx_d = sel_idx_q;
        sel_hi_d  = sel_hi_q;
        unique case (state_q)
            ST_IDLE: if (cand_ok) begin
                state_d   = ST_REQUEST;
                sel_idx_d = cand_idx;
                sel_hi_d  = cand_hi;
            end
            ST_REQUEST: if (core_ack) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sel_idx_q <= '0;
            sel_hi_q  <= 1'b0;
        end else begin
            state_q   <= state_d;
            sel_idx_q <= sel_idx_d;
            sel_hi_q  <= sel_hi_d;
        end
    end

    // Outputs.
    always_comb begin
        irq_strobe = (state_q == ST_REQUEST);
        irq_vector = irq_strobe ? vec_addr(sel_idx_q) : '0;
        take       = irq_strobe && core_ack;
    end

    irq_inservice u_isr (
        .clk(clk), .rst_n(rst_n),
        .take_hi(take && sel_hi_q), .take_lo(take && !sel_hi_q),
        .reti(core_reti), .active(isr_level)
    );

    // R10
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_strobe && !core_ack) |=> (irq_strobe && $stable(irq_vector)));
    // R6
    no_grant_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_strobe && !$past(irq_strobe)) |-> !$past(isr_level[1]));
    // R6
    no_low_over_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_strobe && !$past(irq_strobe) && $past(isr_level[0])) |-> sel_hi_q);
    // R8
    gate_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_strobe && !$past(irq_strobe) && !$past(glob_en)) |-> (sel_idx_q == IDXW'(WDT_IDX)));
    // R4
    vector_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |-> (irq_vector[2:0] == 3'b011));
endmodule

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [10:0] irq_req = '0, irq_en = '0, irq_prio = '0;
    logic        glob_en = 1'b0, wdt_mode = 1'b0, core_ack = 1'b0, core_reti = 1'b0;
    logic        irq_strobe;
    logic [15:0] irq_vector;
    logic [1:0]  isr_level;

    irq_nest_ctrl dut (.*);

    int errors = 0, checks = 0, cycles = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int vec_of(input int i);
        case (i)
            0: return 'h43;  1: return 'h5B;  2: return 'h03;  3: return 'h33;
            4: return 'h0B;  5: return 'h13;  6: return 'h1B;  7: return 'h3B;
            8: return 'h23;  9: return 'h2B;  10: return 'h53;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_hi(input int i, input logic [10:0] pr);
        return (i == 1) ? 1'b1 : pr[i];
    endfunction

    function automatic int model(input logic [10:0] rq, en, pr, input logic ge, wm,
                                 input logic [1:0] lvl);
        int bh = -1, bl = -1;
        for (int i = 0; i < 11; i++) begin
            bit q = (i == 1) ? (rq[i] & wm) : (rq[i] & en[i] & ge);
            if (q && is_hi(i, pr) && bh < 0) bh = i;
            if (q && !is_hi(i, pr) && bl < 0) bl = i;
        end
        if (!lvl[1] && bh >= 0) return bh;
        if (lvl == 2'b00 && bl >= 0) return bl;
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_req = '0; core_ack = 0; core_reti = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive(input logic [10:0] rq, en, pr, input logic ge, wm);
        @(negedge clk);
        irq_req = rq; irq_en = en; irq_prio = pr; glob_en = ge; wdt_mode = wm;
    endtask

    // apply one configuration from reset, check grant and acknowledged level
    task automatic try_case(input logic [10:0] rq, en, pr, input logic ge, wm, input string tag);
        int exp;
        do_reset();
        exp = model(rq, en, pr, ge, wm, 2'b00);
        drive(rq, en, pr, ge, wm);
        @(posedge clk); #1;
        chk(irq_strobe == (exp >= 0), {tag, " R12 strobe"}, irq_strobe, exp >= 0);
        if (exp >= 0) begin
            chk(irq_vector == 16'(vec_of(exp)), {tag, " R2 R3 R4 vector"}, irq_vector, vec_of(exp));
            @(negedge clk); core_ack = 1; irq_req = '0;
            @(posedge clk); #1;
            chk(isr_level == (is_hi(exp, pr) ? 2'b10 : 2'b01), {tag, " R11 level"},
                isr_level, is_hi(exp, pr) ? 2 : 1);
            @(negedge clk); core_ack = 0;
        end
    endtask

    task automatic take_now();
        @(negedge clk); core_ack = 1; irq_req = '0;
        @(negedge clk); core_ack = 0;
    endtask

    task automatic reti_now();
        @(negedge clk); core_reti = 1;
        @(negedge clk); core_reti = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog R12 actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        chk(irq_strobe == 0, "R1 strobe", irq_strobe, 0);
        chk(isr_level == 2'b00, "R1 level", isr_level, 0);

        // singles, both priorities
        for (int i = 0; i < 11; i++)
            for (int p = 0; p < 2; p++)
                try_case(11'(1 << i), '1, p ? '1 : '0, 1'b1, 1'b1, "single");
        // ordered pairs, four priority combinations
        for (int i = 0; i < 11; i++)
            for (int j = 0; j < 11; j++)
                if (i != j)
                    for (int pc = 0; pc < 4; pc++) begin
                        logic [10:0] pr = '0;
                        pr[i] = pc[0]; pr[j] = pc[1];
                        try_case(11'((1 << i) | (1 << j)), '1, pr, 1'b1, 1'b1, "pair R2 R3");
                    end
        // R9 enable cleared per source; R7 watchdog with mode clear
        for (int i = 0; i < 11; i++)
            try_case(11'(1 << i), ~11'(1 << i), '0, 1'b1, (i == 1) ? 1'b0 : 1'b1, "R9 R7 masked");
        // R8 / R7 global enable cleared per source
        for (int i = 0; i < 11; i++)
            try_case(11'(1 << i), '1, '0, 1'b0, 1'b1, "R8 R7 global");

        // R8 pending survives global disable
        do_reset();
        drive(11'h010, '1, '0, 1'b0, 1'b0);
        repeat (3) @(posedge clk); #1;
        chk(irq_strobe == 0, "R8 held off", irq_strobe, 0);
        @(negedge clk); glob_en = 1;
        @(posedge clk); #1;
        chk(irq_strobe && irq_vector == 16'h000B, "R8 resumes", irq_vector, 'h0B);

        // R10 hold after request drops
        @(negedge clk); irq_req = '0;
        repeat (3) @(posedge clk); #1;
        chk(irq_strobe && irq_vector == 16'h000B, "R10 hold", irq_vector, 'h0B);
        take_now(); #1;
        chk(isr_level == 2'b01, "R11 low taken", isr_level, 1);

        // R6 low blocked while low in service
        drive(11'h004, '1, '0, 1'b1, 1'b0);
        repeat (3) @(posedge clk); #1;
        chk(irq_strobe == 0, "R6 low over low", irq_strobe, 0);
        // R5 high preempts low
        drive(11'h008, '1, 11'h008, 1'b1, 1'b0);
        @(posedge clk); #1;
        chk(irq_strobe && irq_vector == 16'h0033, "R5 preempt", irq_vector, 'h33);
        take_now(); #1;
        chk(isr_level == 2'b11, "R11 nested", isr_level, 3);
        // R6 nothing while high in service, not even watchdog
        drive(11'h00B, '1, 11'h008, 1'b1, 1'b1);
        repeat (3) @(posedge clk); #1;
        chk(irq_strobe == 0, "R6 high blocks", irq_strobe, 0);
        @(negedge clk); irq_req = '0;
        reti_now(); #1;
        chk(isr_level == 2'b01, "R11 reti high first", isr_level, 1);
        reti_now(); #1;
        chk(isr_level == 2'b00, "R11 reti low", isr_level, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule